// File: doc/BRIEF.md
# Bus Register-Access Protection Gate

This block sits on the path from a bus interconnect to the memory-mapped registers of a set of peripherals. Each request names a target peripheral by index, an offset inside it, a write flag, a requester ID and a secure attribute. The gate takes in one request at a time and checks it against that peripheral's settings. It then either forwards the request to the peripheral side or ends it at once with a bus error response. Blocked requests are recorded in sticky status bits, which can drive one interrupt line.

Each peripheral has its own write-protect mask. The mask has one bit per core requester and one bit per system requester. Each peripheral also has a completer-secure bit, which rejects non-secure traffic. A keyed global lock works together with a lock-enable bit to freeze the write-protect masks against further change. A separate configuration port gives access to the control register, the secure control register, the status register and the per-peripheral registers.

The request path is a four-state machine:
- `ST_IDLE` accepts a request and moves to `ST_CHECK`.
- `ST_CHECK` evaluates the latched request.
  - A pass moves to `ST_FWD`.
  - A block moves to `ST_RESP` with the error flag set.
- `ST_FWD` holds the forwarded request until the peripheral signals ready, then moves to `ST_RESP`.
- `ST_RESP` presents a one-cycle response and returns to `ST_IDLE`.

Top module: `bus_prot_gate`

## Requirements
- R1: After reset the control register reads 0x000000AD, so the lock key holds the unlock value and the system is unlocked. All write-protect masks, completer-secure bits and status bits read zero, and `irq` is low.
- R2: The requester IDs map onto write-protect mask bits as follows:
  - IDs 0..2 are core requesters and map to mask bits 0..2.
  - IDs 3..5 are system requesters and map to mask bits 16..18.
  - A write whose requester's bit is set in the target peripheral's mask is blocked.
  - IDs 6 and 7 have no mask bit and are never blocked by write protection.
- R3: A blocked request is never forwarded. It gets a one-cycle response with `rsp_err`=1 and `rsp_rdata`=0. An allowed request is forwarded and answered with `rsp_err`=0. A read returns the peripheral's data; a write returns zero data.
- R4: The protection decision is taken once, in the check cycle. A mask change made while a request is being forwarded does not affect that request, but it does apply to every later one.
- R5: Reads are never blocked by write protection.
- R6: The global lock is active whenever the lock key (control bits 7:0) differs from 0xAD.
  - While the lock is active and the write-protect-lock bit (control bit 8) is set, configuration writes to the write-protect masks are ignored and set the lock-write-error status bit.
  - With the key at 0xAD, or with the lock bit clear, such writes take effect.
- R7: A non-secure access, read or write, to a peripheral whose completer-secure bit is set is blocked. Secure accesses pass this check. When the bit is clear the secure attribute is ignored. If an access fails both the secure check and the write-protect check, it counts as a security violation only.
- R8: The status register (address 2) has four bits:
  - bit 0 is the lock-write error;
  - bit 1 is the violation request, set by either kind of violation;
  - bit 2 is the protection-violation flag;
  - bit 3 is the security-violation flag.

  Writing 1 clears a bit. A set event in the same cycle wins over the clear.
- R9: `irq` is high exactly when the violation-request bit is set and at least one enabled flag is set. A flag counts as enabled in two cases:
  - the protection flag is set and the protection-interrupt enable (control bit 9) is set;
  - the security flag is set and the secure-interrupt enable (secure control register, address 1, bit 0) is set.
- R10: The configuration map is:
  - control register at address 0;
  - secure control register at address 1;
  - status register at address 2;
  - write-protect mask of peripheral p at address 16+p, which stores only bits 2:0 and 18:16;
  - completer-secure bit of peripheral p at address 32+p, bit 0.

  Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate is idle and takes the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_periph | input | 2 | Target peripheral index |
| req_offset | input | 8 | Register offset inside the peripheral |
| req_wdata | input | 32 | Write data |
| req_rid | input | 3 | Requester ID |
| req_secure | input | 1 | 1 for a secure transaction |
| fwd_valid | output | 1 | Forwarded request present |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_periph | output | 2 | Forwarded peripheral index |
| fwd_offset | output | 8 | Forwarded offset |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_secure | output | 1 | Forwarded secure attribute |
| fwd_ready | input | 1 | Peripheral completes the forwarded request |
| fwd_rdata | input | 32 | Peripheral read data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Bus error on the response |
| rsp_rdata | output | 32 | Response read data |
| cfg_wen | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| irq | output | 1 | Violation interrupt |

## Verification
The bound checker covers the properties that can be judged every cycle:
- a stalled forwarded request stays stable;
- a response lasts one cycle and never overlaps forwarding, and an error response carries zero data;
- non-secure traffic never reaches a peripheral that was marked secure at the time of the check;
- masks stay frozen under the active lock;
- the lock-write error is set and stays sticky;
- `irq` never rises without the violation request.

Other behaviours show up only in the bench's scenarios:
- the mapping of requester IDs onto mask bits;
- an in-flight write that completes across a mask change;
- the precedence of the security check over write protection;
- the clear-on-write-one behaviour of the status bits;
- the fact that a fully locked mask cannot be undone while the lock holds.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    localparam int CFG_AW = 6;
    localparam logic [CFG_AW-1:0] A_CTRL    = 6'd0;
    localparam logic [CFG_AW-1:0] A_SECCTL  = 6'd1;
    localparam logic [CFG_AW-1:0] A_STAT    = 6'd2;
    localparam logic [CFG_AW-1:0] A_WP_BASE = 6'd16;
    localparam logic [CFG_AW-1:0] A_SP_BASE = 6'd32;
    localparam logic [7:0] UNLOCK_KEY = 8'hAD;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FWD   = 2'd2,
        ST_RESP  = 2'd3
    } gate_state_e;

    typedef enum logic [1:0] {
        VD_PASS = 2'd0,
        VD_PROT = 2'd1,
        VD_SEC  = 2'd2
    } verdict_e;
endpackage

// File: rtl/bpg_cfg_regs.sv
module bpg_cfg_regs
    import bpg_pkg::*;
#(
    parameter int NUM_PERIPH = 4,
    parameter int NUM_CORE   = 3,
    parameter int NUM_SYS    = 3,
    parameter int SYS_BASE   = 16,
    parameter int DATA_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wen,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [DATA_W-1:0]            cfg_wdata,
    output logic [DATA_W-1:0]            cfg_rdata,
    input  logic                         ev_prot,
    input  logic                         ev_sec,
    output logic [NUM_PERIPH*DATA_W-1:0] wp_flat,
    output logic [NUM_PERIPH-1:0]        secp,
    output logic                         lock_active,
    output logic                         wplk,
    output logic                         lwerr,
    output logic                         virq,
    output logic                         irq
);
    localparam int PIDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

    function automatic logic [DATA_W-1:0] keep_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_CORE; i++) m[i] = 1'b1;
        for (int i = 0; i < NUM_SYS; i++)  m[SYS_BASE+i] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] WP_KEEP = keep_mask();

    logic [7:0]        key_q;
    logic              wplk_q, pen_q, sen_q;
    logic [DATA_W-1:0] wp_q [NUM_PERIPH];
    logic [NUM_PERIPH-1:0] sp_q;
    logic              lwerr_q, virq_q, pflag_q, sflag_q;

    logic [CFG_AW-1:0] wp_off, sp_off;
    logic              wp_hit, sp_hit, wp_frozen, lw_set;
    logic [3:0]        stat_clr;

    assign wp_off    = cfg_addr - A_WP_BASE;
    assign sp_off    = cfg_addr - A_SP_BASE;
    assign wp_hit    = (int'(cfg_addr) >= int'(A_WP_BASE)) &&
                       (int'(cfg_addr) <  int'(A_WP_BASE) + NUM_PERIPH);
    assign sp_hit    = (int'(cfg_addr) >= int'(A_SP_BASE)) &&
                       (int'(cfg_addr) <  int'(A_SP_BASE) + NUM_PERIPH);
    assign lock_active = (key_q != UNLOCK_KEY);
    assign wp_frozen = wplk_q && lock_active;
    assign lw_set    = cfg_wen && wp_hit && wp_frozen;
    assign stat_clr  = (cfg_wen && cfg_addr == A_STAT) ? cfg_wdata[3:0] : 4'b0;

    // control and secure control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= UNLOCK_KEY;
            wplk_q <= 1'b0;
            pen_q  <= 1'b0;
            sen_q  <= 1'b0;
        end else if (cfg_wen) begin
            if (cfg_addr == A_CTRL) begin
                key_q  <= cfg_wdata[7:0];
                wplk_q <= cfg_wdata[8];
                pen_q  <= cfg_wdata[9];
            end
            if (cfg_addr == A_SECCTL) sen_q <= cfg_wdata[0];
        end
    end

    // per-peripheral protect masks and secure bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PERIPH; p++) wp_q[p] <= '0;
            sp_q <= '0;
        end else if (cfg_wen) begin
            for (int p = 0; p < NUM_PERIPH; p++) begin
                if (wp_hit && !wp_frozen && wp_off == CFG_AW'(p))
                    wp_q[p] <= cfg_wdata & WP_KEEP;
                if (sp_hit && sp_off == CFG_AW'(p))
                    sp_q[p] <= cfg_wdata[0];
            end
        end
    end

    // sticky status, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lwerr_q <= 1'b0;
            virq_q  <= 1'b0;
            pflag_q <= 1'b0;
            sflag_q <= 1'b0;
        end else begin
            lwerr_q <= (lwerr_q & ~stat_clr[0]) | lw_set;
            virq_q  <= (virq_q  & ~stat_clr[1]) | ev_prot | ev_sec;
            pflag_q <= (pflag_q & ~stat_clr[2]) | ev_prot;
            sflag_q <= (sflag_q & ~stat_clr[3]) | ev_sec;
        end
    end

    generate
        for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_pack
            assign wp_flat[p*DATA_W +: DATA_W] = wp_q[p];
        end
    endgenerate

    assign secp  = sp_q;
    assign wplk  = wplk_q;
    assign lwerr = lwerr_q;
    assign virq  = virq_q;
    assign irq   = virq_q & ((pflag_q & pen_q) | (sflag_q & sen_q));

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == A_CTRL) begin
            cfg_rdata[7:0] = key_q;
            cfg_rdata[8]   = wplk_q;
            cfg_rdata[9]   = pen_q;
        end else if (cfg_addr == A_SECCTL) begin
            cfg_rdata[0] = sen_q;
        end else if (cfg_addr == A_STAT) begin
            cfg_rdata[3:0] = {sflag_q, pflag_q, virq_q, lwerr_q};
        end else if (wp_hit) begin
            cfg_rdata = wp_q[wp_off[PIDX_W-1:0]];
        end else if (sp_hit) begin
            cfg_rdata[0] = sp_q[sp_off[PIDX_W-1:0]];
        end
    end
endmodule

// File: rtl/bpg_access_check.sv
module bpg_access_check
    import bpg_pkg::*;
#(
    parameter int NUM_PERIPH = 4,
    parameter int NUM_CORE   = 3,
    parameter int NUM_SYS    = 3,
    parameter int SYS_BASE   = 16,
    parameter int DATA_W     = 32,
    parameter int RID_W      = 3,
    localparam int PIDX_W    = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                         chk_write,
    input  logic [RID_W-1:0]             chk_rid,
    input  logic                         chk_secure,
    input  logic [PIDX_W-1:0]            chk_periph,
    input  logic [NUM_PERIPH*DATA_W-1:0] wp_flat,
    input  logic [NUM_PERIPH-1:0]        secp,
    output verdict_e                     verdict
);
    localparam int NUM_REQ = NUM_CORE + NUM_SYS;

    logic [NUM_REQ-1:0] req_onehot;
    logic [NUM_REQ-1:0] mask_bits;
    logic               wp_hit_req;
    logic               sec_block;

    generate
        for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
            localparam int BITPOS = (r < NUM_CORE) ? r : SYS_BASE + (r - NUM_CORE);
            assign req_onehot[r] = (chk_rid == RID_W'(r));
            assign mask_bits[r]  = wp_flat[int'(chk_periph)*DATA_W + BITPOS];
        end
    endgenerate

    assign wp_hit_req = |(req_onehot & mask_bits);
    assign sec_block  = secp[chk_periph] && !chk_secure;

    always_comb begin
        if (sec_block)                    verdict = VD_SEC;
        else if (chk_write && wp_hit_req) verdict = VD_PROT;
        else                              verdict = VD_PASS;
    end
endmodule

// File: rtl/bpg_req_fsm.sv
module bpg_req_fsm
    import bpg_pkg::*;
#(
    parameter int PIDX_W = 2,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 32,
    parameter int RID_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [PIDX_W-1:0] req_periph,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [RID_W-1:0]  req_rid,
    input  logic              req_secure,
    input  verdict_e          verdict,
    output logic              chk_write,
    output logic [RID_W-1:0]  chk_rid,
    output logic              chk_secure,
    output logic [PIDX_W-1:0] chk_periph,
    output logic              fwd_valid,
    output logic [OFF_W-1:0]  fwd_offset,
    output logic [DATA_W-1:0] fwd_wdata,
    input  logic              fwd_ready,
    input  logic [DATA_W-1:0] fwd_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ev_prot,
    output logic              ev_sec
);
    gate_state_e state_q, state_d;

    logic              wr_q, sec_q, err_q;
    logic [RID_W-1:0]  rid_q;
    logic [PIDX_W-1:0] per_q;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] wdat_q, rdat_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: state_d = (verdict == VD_PASS) ? ST_FWD : ST_RESP;
            ST_FWD:   if (fwd_ready) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            sec_q  <= 1'b0;
            rid_q  <= '0;
            per_q  <= '0;
            off_q  <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                wr_q   <= req_write;
                sec_q  <= req_secure;
                rid_q  <= req_rid;
                per_q  <= req_periph;
                off_q  <= req_offset;
                wdat_q <= req_wdata;
            end
            if (state_q == ST_CHECK && verdict != VD_PASS) begin
                err_q  <= 1'b1;
                rdat_q <= '0;
            end
            if (state_q == ST_FWD && fwd_ready) begin
                err_q  <= 1'b0;
                rdat_q <= wr_q ? '0 : fwd_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        fwd_valid  = (state_q == ST_FWD);
        rsp_valid  = (state_q == ST_RESP);
        rsp_err    = err_q;
        rsp_rdata  = rdat_q;
        ev_prot    = (state_q == ST_CHECK) && (verdict == VD_PROT);
        ev_sec     = (state_q == ST_CHECK) && (verdict == VD_SEC);
        chk_write  = wr_q;
        chk_rid    = rid_q;
        chk_secure = sec_q;
        chk_periph = per_q;
        fwd_offset = off_q;
        fwd_wdata  = wdat_q;
    end
endmodule

// File: rtl/bus_prot_gate.sv
module bus_prot_gate
    import bpg_pkg::*;
#(
    parameter int NUM_PERIPH = 4,
    parameter int NUM_CORE   = 3,
    parameter int NUM_SYS    = 3,
    parameter int SYS_BASE   = 16,
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 8,
    parameter int RID_W      = 3,
    localparam int PIDX_W    = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [PIDX_W-1:0] req_periph,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [RID_W-1:0]  req_rid,
    input  logic              req_secure,
    output logic              fwd_valid,
    output logic              fwd_write,
    output logic [PIDX_W-1:0] fwd_periph,
    output logic [OFF_W-1:0]  fwd_offset,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic              fwd_secure,
    input  logic              fwd_ready,
    input  logic [DATA_W-1:0] fwd_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              cfg_wen,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              irq
);
    logic [NUM_PERIPH*DATA_W-1:0] wp_flat;
    logic [NUM_PERIPH-1:0]        secp;
    logic                         lock_active, wplk, lwerr, virq;
    logic                         ev_prot, ev_sec;
    logic                         chk_write, chk_secure;
    logic [RID_W-1:0]             chk_rid;
    logic [PIDX_W-1:0]            chk_periph;
    verdict_e                     verdict;

    bpg_cfg_regs #(
        .NUM_PERIPH(NUM_PERIPH), .NUM_CORE(NUM_CORE), .NUM_SYS(NUM_SYS),
        .SYS_BASE(SYS_BASE), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_wen(cfg_wen), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .ev_prot(ev_prot), .ev_sec(ev_sec),
        .wp_flat(wp_flat), .secp(secp), .lock_active(lock_active),
        .wplk(wplk), .lwerr(lwerr), .virq(virq), .irq(irq)
    );

    bpg_access_check #(
        .NUM_PERIPH(NUM_PERIPH), .NUM_CORE(NUM_CORE), .NUM_SYS(NUM_SYS),
        .SYS_BASE(SYS_BASE), .DATA_W(DATA_W), .RID_W(RID_W)
    ) u_chk (
        .chk_write(chk_write), .chk_rid(chk_rid), .chk_secure(chk_secure),
        .chk_periph(chk_periph), .wp_flat(wp_flat), .secp(secp),
        .verdict(verdict)
    );

    bpg_req_fsm #(
        .PIDX_W(PIDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .RID_W(RID_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_periph(req_periph), .req_offset(req_offset), .req_wdata(req_wdata),
        .req_rid(req_rid), .req_secure(req_secure),
        .verdict(verdict),
        .chk_write(chk_write), .chk_rid(chk_rid), .chk_secure(chk_secure),
        .chk_periph(chk_periph),
        .fwd_valid(fwd_valid), .fwd_offset(fwd_offset), .fwd_wdata(fwd_wdata),
        .fwd_ready(fwd_ready), .fwd_rdata(fwd_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ev_prot(ev_prot), .ev_sec(ev_sec)
    );

    assign fwd_write  = chk_write;
    assign fwd_periph = chk_periph;
    assign fwd_secure = chk_secure;
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
    parameter int NUM_PERIPH = 4,
    parameter int DATA_W     = 32,
    parameter int PIDX_W     = 2,
    parameter int OFF_W      = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         fwd_valid,
    input logic                         fwd_ready,
    input logic                         fwd_write,
    input logic [PIDX_W-1:0]            fwd_periph,
    input logic [OFF_W-1:0]             fwd_offset,
    input logic                         fwd_secure,
    input logic                         rsp_valid,
    input logic                         rsp_err,
    input logic [DATA_W-1:0]            rsp_rdata,
    input logic                         cfg_wen,
    input logic [5:0]                   cfg_addr,
    input logic                         clr_lw_bit,
    input logic [NUM_PERIPH*DATA_W-1:0] wp_flat,
    input logic [NUM_PERIPH-1:0]        secp,
    input logic                         lock_active,
    input logic                         wplk,
    input logic                         lwerr,
    input logic                         virq,
    input logic                         irq
);
    logic wp_addr;
    assign wp_addr = (int'(cfg_addr) >= 16) && (int'(cfg_addr) < 16 + NUM_PERIPH);

    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_periph) && $stable(fwd_write) && $stable(fwd_offset)); // R4
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3
    AST_RSP_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !fwd_valid); // R3
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_rdata == '0); // R3
    AST_SEC_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_valid) && !fwd_secure |-> !$past(secp[fwd_periph])); // R7
    AST_WP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wen && wp_addr && wplk && lock_active |=> $stable(wp_flat)); // R6
    AST_LWERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wen && wp_addr && wplk && lock_active |=> lwerr); // R6
    AST_LWERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lwerr && !(cfg_wen && cfg_addr == 6'd2 && clr_lw_bit) |=> lwerr); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> virq); // R9
endmodule

bind bus_prot_gate bpg_checker #(
    .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W), .PIDX_W(PIDX_W), .OFF_W(OFF_W)
) u_bpg_checker (
    .clk(clk), .rst_n(rst_n),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_write(fwd_write),
    .fwd_periph(fwd_periph), .fwd_offset(fwd_offset), .fwd_secure(fwd_secure),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_wen(cfg_wen), .cfg_addr(cfg_addr), .clr_lw_bit(cfg_wdata[0]),
    .wp_flat(wp_flat), .secp(secp), .lock_active(lock_active),
    .wplk(wplk), .lwerr(lwerr), .virq(virq), .irq(irq)
);

// File: tb/bus_prot_gate_tb_top.sv
`timescale 1ns/1ps
module bus_prot_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [1:0]  req_periph = '0;
    logic [7:0]  req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  req_rid = '0;
    logic        req_ready, fwd_valid, fwd_write, fwd_secure, fwd_ready;
    logic [1:0]  fwd_periph;
    logic [7:0]  fwd_offset;
    logic [31:0] fwd_wdata, fwd_rdata, rsp_rdata, cfg_rdata;
    logic        rsp_valid, rsp_err, irq;
    logic        cfg_wen = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hold_fwd = 1'b0;
    logic        fwd_seen = 1'b0;

    integer n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    assign fwd_ready = fwd_valid && !hold_fwd;
    assign fwd_rdata = {16'hA500, 6'b0, fwd_periph, fwd_offset};

    bus_prot_gate dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_periph(req_periph), .req_offset(req_offset), .req_wdata(req_wdata),
        .req_rid(req_rid), .req_secure(req_secure),
        .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_periph(fwd_periph),
        .fwd_offset(fwd_offset), .fwd_wdata(fwd_wdata), .fwd_secure(fwd_secure),
        .fwd_ready(fwd_ready), .fwd_rdata(fwd_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cfg_wen(cfg_wen), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_key;
    logic        m_wplk, m_pen, m_sen, m_lw, m_virq, m_pf, m_sf;
    logic [31:0] m_wp [4];
    logic        m_sp [4];
    logic        pend, p_wr, p_sec;
    integer      p_rid, p_per;
    bit          exp_q [$];

    function automatic integer rid_bit(input integer rid);
        if (rid < 3) return rid;
        if (rid < 6) return 16 + rid - 3;
        return -1;
    endfunction

    function automatic logic [31:0] model_read(input logic [5:0] a);
        logic [31:0] v;
        v = 32'h0;
        if (a == 6'd0) v = {22'h0, m_pen, m_wplk, m_key};
        else if (a == 6'd1) v = {31'h0, m_sen};
        else if (a == 6'd2) v = {28'h0, m_sf, m_pf, m_virq, m_lw};
        else if (a >= 6'd16 && a < 6'd20) v = m_wp[a - 6'd16];
        else if (a >= 6'd32 && a < 6'd36) v = {31'h0, m_sp[a - 6'd32]};
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_key = 8'hAD; m_wplk = 0; m_pen = 0; m_sen = 0;
            m_lw = 0; m_virq = 0; m_pf = 0; m_sf = 0; pend = 0;
            p_wr = 0; p_sec = 0; p_rid = 0; p_per = 0;
            for (int i = 0; i < 4; i++) begin m_wp[i] = 0; m_sp[i] = 0; end
        end else begin
            logic ep, es, lws;
            logic [3:0] clr;
            integer b;
            ep = 0; es = 0; lws = 0;
            if (pend) begin
                b = rid_bit(p_rid);
                if (m_sp[p_per] && !p_sec) es = 1;
                else if (p_wr && b >= 0 && m_wp[p_per][b]) ep = 1;
                exp_q.push_back(ep | es);
            end
            clr = (cfg_wen && cfg_addr == 6'd2) ? cfg_wdata[3:0] : 4'h0;
            if (cfg_wen) begin
                if (cfg_addr == 6'd0) begin
                    m_key = cfg_wdata[7:0]; m_wplk = cfg_wdata[8]; m_pen = cfg_wdata[9];
                end else if (cfg_addr == 6'd1) m_sen = cfg_wdata[0];
                else if (cfg_addr >= 6'd16 && cfg_addr < 6'd20) begin
                    if (m_wplk && m_key != 8'hAD) lws = 1;
                    else m_wp[cfg_addr - 6'd16] = cfg_wdata & 32'h0007_0007;
                end else if (cfg_addr >= 6'd32 && cfg_addr < 6'd36)
                    m_sp[cfg_addr - 6'd32] = cfg_wdata[0];
            end
            m_lw   = (m_lw   & ~clr[0]) | lws;
            m_virq = (m_virq & ~clr[1]) | ep | es;
            m_pf   = (m_pf   & ~clr[2]) | ep;
            m_sf   = (m_sf   & ~clr[3]) | es;
            pend = req_valid;
            if (req_valid) begin
                p_wr = req_write; p_sec = req_secure;
                p_rid = req_rid; p_per = req_periph;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model (R10 readback, R9 interrupt)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cfg_rdata == model_read(cfg_addr), "R10 model readback", cfg_rdata, model_read(cfg_addr));
            chk(irq == (m_virq & ((m_pf & m_pen) | (m_sf & m_sen))), "R9 model irq",
                {31'h0, irq}, {31'h0, m_virq & ((m_pf & m_pen) | (m_sf & m_sen))});
            if (fwd_valid) fwd_seen = 1'b1;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_wen = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wen = 0;
    endtask

    task automatic cfg_chk(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        cfg_addr = a;
        @(negedge clk);
        chk(cfg_rdata == e, tag, cfg_rdata, e);
    endtask

    task automatic send_req(input bit w, input logic [2:0] rid, input bit sec,
                            input logic [1:0] per, input logic [7:0] off);
        @(posedge clk); #1;
        fwd_seen = 0;
        req_valid = 1; req_write = w; req_rid = rid; req_secure = sec;
        req_periph = per; req_offset = off; req_wdata = 32'h1234_0000 | {24'h0, off};
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic wait_rsp(input bit e_err, input logic [31:0] e_data, input string tag);
        bit got, m_err;
        got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if (rsp_valid) got = 1;
        end
        chk(got, {tag, " response seen"}, {31'h0, got}, 32'h1);
        if (got) begin
            chk(rsp_err == e_err, {tag, " rsp_err"}, {31'h0, rsp_err}, {31'h0, e_err});
            chk(rsp_rdata == e_data, {tag, " rsp_rdata"}, rsp_rdata, e_data);
            chk(fwd_seen == !e_err, {tag, " forwarded"}, {31'h0, fwd_seen}, {31'h0, !e_err});
            m_err = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
            chk(rsp_err == m_err, {tag, " model verdict"}, {31'h0, rsp_err}, {31'h0, m_err});
        end
    endtask

    task automatic access(input bit w, input logic [2:0] rid, input bit sec,
                          input logic [1:0] per, input logic [7:0] off,
                          input bit e_err, input string tag);
        logic [31:0] ed;
        ed = (e_err || w) ? 32'h0 : {16'hA500, 6'b0, per, off};
        send_req(w, rid, sec, per, off);
        wait_rsp(e_err, ed, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        cfg_chk(6'd0, 32'h0000_00AD, "R1 control after reset");
        cfg_chk(6'd2, 32'h0, "R1 status after reset");
        cfg_chk(6'd17, 32'h0, "R1 mask after reset");
        cfg_chk(6'd33, 32'h0, "R1 secure bit after reset");
        chk(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);

        // R10 map and stored bits
        cfg_wr(6'd16, 32'hFFFF_FFFF);
        cfg_chk(6'd16, 32'h0007_0007, "R10 mask stored bits");
        cfg_wr(6'd34, 32'hFFFF_FFFF);
        cfg_chk(6'd34, 32'h1, "R10 secure bit");
        cfg_chk(6'd5, 32'h0, "R10 unmapped reads zero");
        cfg_wr(6'd16, 32'h0);
        cfg_wr(6'd34, 32'h0);

        // R2 requester mapping, R3 responses
        cfg_wr(6'd17, 32'h0002_0002);
        access(1, 3'd1, 1, 2'd1, 8'h10, 1, "R2 core1 blocked");
        access(1, 3'd0, 1, 2'd1, 8'h11, 0, "R2 core0 passes");
        access(1, 3'd4, 1, 2'd1, 8'h12, 1, "R2 sys bit17 blocked");
        access(1, 3'd3, 1, 2'd1, 8'h13, 0, "R2 sys bit16 passes");
        access(1, 3'd7, 1, 2'd1, 8'h14, 0, "R2 unmapped id passes");
        access(0, 3'd2, 0, 2'd0, 8'h3C, 0, "R3 allowed read data");
        // R5 reads ignore write protection
        access(0, 3'd1, 1, 2'd1, 8'h20, 0, "R5 read not write blocked");

        // R8 and R9 status and interrupt
        cfg_chk(6'd2, 32'h6, "R8 prot flags set");
        chk(irq == 1'b0, "R9 irq masked", {31'h0, irq}, 32'h0);
        cfg_wr(6'd0, 32'h0000_02AD);
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq with prot enable", {31'h0, irq}, 32'h1);
        cfg_wr(6'd2, 32'h4);
        cfg_chk(6'd2, 32'h2, "R8 w1c single bit");
        chk(irq == 1'b0, "R9 irq after prot flag clear", {31'h0, irq}, 32'h0);
        cfg_wr(6'd2, 32'hF);
        cfg_chk(6'd2, 32'h0, "R8 w1c all");

        // R7 secure filtering
        cfg_wr(6'd34, 32'h1);
        access(0, 3'd0, 0, 2'd2, 8'h01, 1, "R7 nonsecure read blocked");
        access(0, 3'd0, 1, 2'd2, 8'h02, 0, "R7 secure read passes");
        access(1, 3'd0, 0, 2'd3, 8'h03, 0, "R7 attribute ignored when clear");
        cfg_chk(6'd2, 32'hA, "R7 security flags");
        chk(irq == 1'b0, "R9 sec event without sec enable", {31'h0, irq}, 32'h0);
        cfg_wr(6'd1, 32'h1);
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq with sec enable", {31'h0, irq}, 32'h1);
        cfg_wr(6'd2, 32'hF);
        cfg_wr(6'd18, 32'h1);
        access(1, 3'd0, 0, 2'd2, 8'h04, 1, "R7 precedence over protect");
        cfg_chk(6'd2, 32'hA, "R7 counted as security only");
        cfg_wr(6'd2, 32'hF);

        // R4 in-flight write completes across a mask change
        hold_fwd = 1;
        send_req(1, 3'd0, 1, 2'd0, 8'h40);
        cfg_wr(6'd16, 32'h1);
        hold_fwd = 0;
        wait_rsp(0, 32'h0, "R4 in-flight write completes");
        access(1, 3'd0, 1, 2'd0, 8'h41, 1, "R4 later write blocked");
        cfg_wr(6'd2, 32'hF);

        // R6 global lock and self protection
        cfg_wr(6'd0, 32'h0000_0000);
        cfg_wr(6'd19, 32'h7);
        cfg_chk(6'd19, 32'h7, "R6 lock without lock bit allows update");
        cfg_wr(6'd0, 32'h0000_0155);
        cfg_wr(6'd19, 32'h0);
        cfg_chk(6'd19, 32'h7, "R6 locked mask unchanged");
        cfg_chk(6'd2, 32'h1, "R6 lock write error");
        cfg_wr(6'd0, 32'h0000_01AD);
        cfg_wr(6'd19, 32'h0007_0007);
        cfg_chk(6'd19, 32'h0007_0007, "R6 key unlocks update");
        cfg_wr(6'd0, 32'h0000_0101);
        cfg_wr(6'd19, 32'h0);
        cfg_chk(6'd19, 32'h0007_0007, "R6 full lockout persists");
        for (int r = 0; r < 6; r++)
            access(1, 3'(r), 1, 2'd3, 8'h50, 1, "R6 every requester blocked");
        cfg_chk(6'd2, 32'h7, "R8 lwerr sticky with prot flags");

        repeat (3) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule